// File: doc/BRIEF.md
# UART Channel Interrupt Prioritiser with Receive Character Timeout

This block is the interrupt logic of a single UART channel. It takes the receive FIFO fill level, event strobes from the receiver and transmitter, the current modem-delta summary and the register access strobes. It drives one active-high interrupt line and an encoded identification byte that software reads to find the most urgent source. The FIFO storage and the serial framing sit outside the block.

Five sources are combined under a four-bit enable mask:
- a line-status error,
- receive data at or above a programmable trigger level,
- a receive character timeout,
- transmit holding empty,
- modem status.

The timeout counter measures idle time in bit periods. Each bit period is sixteen ticks of the oversampling clock enable. The limit follows the programmed character width, so a partly filled FIFO is still reported once traffic stops.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the identification byte reads 0x01, the enable readback reads 0x00, FIFO mode is off and `irq` is low.
- R2: An enable write keeps `wdata[3:0]`. Bit 0 enables receive data and timeout, bit 1 transmit empty, bit 2 line status and bit 3 modem status. Readback bits 7..4 are always 0.
- R3: Identification bits 3..0 report the highest pending enabled source, in falling order: 0110 line status, 0100 receive data, 1100 timeout, 0010 transmit empty, 0000 modem. The value 0001 means nothing is pending. Bit 0 low therefore means an interrupt is pending.
- R4: `irq` is high exactly when at least one enabled source is pending. A disabled source neither drives `irq` nor appears in the identification byte.
- R5: A FIFO-control write sets FIFO mode from `wdata[0]` and the trigger code from `wdata[7:6]`: 00=1, 01=4, 10=8, 11=14 bytes. In FIFO mode, receive data is pending while `rx_level` is at or above the trigger and clears as soon as it drops below it.
- R6: With FIFO mode off, receive data is pending whenever `rx_level` is nonzero, whatever the trigger code. Identification bits 7..6 read 11 in FIFO mode and 00 otherwise. Bits 5..4 always read 0.
- R7: The timeout becomes pending after 16·(4·W+12) consecutive `tick16` pulses with no restart. W is the character width selected by `word_len` (00=5, 01=6, 10=7, 11=8). The flag is registered, so it appears one clock after the last counted tick.
- R8: The timeout counter restarts on `rx_stop_mid` and on `rx_pop`. A FIFO read also clears a pending timeout. An empty FIFO, or FIFO mode off, holds the counter at zero and clears the flag.
- R9: Transmit empty is set by `thr_empty_evt`. It is cleared by `wr_thr`, or by `rd_isr` in a cycle where the identification reports 0010. A read reporting another code leaves it pending.
- R10: Line status is set by `line_err` and cleared by `rd_lsr`. When both occur in the same cycle, the new error wins and stays pending.
- R11: Modem status is pending while `msr_delta` is high and follows that level directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversampling clock enable, 16 per bit |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_stop_mid | input | 1 | Strobe at centre of a received stop bit |
| rx_pop | input | 1 | Receive FIFO read strobe |
| line_err | input | 1 | Line-status error event |
| thr_empty_evt | input | 1 | Transmit holding became empty |
| msr_delta | input | 1 | Any modem delta flag set |
| word_len | input | 2 | Character width code |
| wr_ier | input | 1 | Enable register write strobe |
| wr_fcr | input | 1 | FIFO control write strobe |
| wr_thr | input | 1 | Transmit holding write strobe |
| rd_isr | input | 1 | Identification read strobe |
| rd_lsr | input | 1 | Line status read strobe |
| wdata | input | 8 | Write data |
| irq | output | 1 | Interrupt request, active high |
| isr_rdata | output | 8 | Identification byte |
| ier_rdata | output | 8 | Enable register readback |

## Verification
Two collisions are provoked on purpose. The first is a fresh `line_err` in the very cycle of an `rd_lsr`; the identification byte sampled after that edge must still show 0110. The second is an `rd_isr` while a line error outranks a pending transmit-empty. The transmit source must survive that read, which is judged by clearing the line error and then seeing 0010. The timeout is judged at the exact tick count: low one clock before the computed edge and high after it, both after a FIFO read and after a stop-bit restart.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_MODEM   = 4'b0000,
    ID_NONE    = 4'b0001,
    ID_TXEMPTY = 4'b0010,
    ID_RXDATA  = 4'b0100,
    ID_LINE    = 4'b0110,
    ID_RXTMO   = 4'b1100
  } irq_id_e;

  // receive trigger threshold in bytes for a two-bit code
  function automatic logic [4:0] trig_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  // idle limit in bit periods: four characters' worth of data bits plus 12
  function automatic logic [7:0] tmo_bits(input logic [1:0] wl);
    logic [7:0] width;
    width = 8'd5 + {6'd0, wl};
    return (width << 2) + 8'd12;
  endfunction

endpackage

// File: rtl/uart_irq_cfg.sv
module uart_irq_cfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ier,
  input  logic       wr_fcr,
  input  logic [7:0] wdata,
  output logic [3:0] ier,
  output logic       fifo_on,
  output logic [1:0] trig_sel
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ier      <= 4'd0;
      fifo_on  <= 1'b0;
      trig_sel <= 2'd0;
    end else begin
      if (wr_ier) ier <= wdata[3:0];
      if (wr_fcr) begin
        fifo_on  <= wdata[0];
        trig_sel <= wdata[7:6];
      end
    end
  end

  assert_ier_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ier |=> ier == $past(wdata[3:0]));

  assert_fcr_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fcr |=> (fifo_on == $past(wdata[0])) && (trig_sel == $past(wdata[7:6])));

endmodule

// File: rtl/uart_irq_trig.sv
module uart_irq_trig #(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             fifo_on,
  input  logic [1:0]       trig_sel,
  output logic             at_trig
);
  import uart_irq_pkg::*;

  logic [LVL_W-1:0] thresh;

  always_comb begin
    if (fifo_on) thresh = LVL_W'(trig_bytes(trig_sel));
    else         thresh = LVL_W'(1);
    at_trig = (rx_level >= thresh);
  end

  assert_legacy_any_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_on && rx_level != '0) |-> at_trig);

  assert_empty_never_triggers_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |-> !at_trig);

endmodule

// File: rtl/uart_irq_tmo.sv
module uart_irq_tmo #(
  parameter int LVL_W = 5,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             fifo_on,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             stop_mid,
  input  logic             rx_pop,
  input  logic [1:0]       word_len,
  output logic             to_pend
);
  import uart_irq_pkg::*;

  localparam int PRE_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int MAX_B = 4 * 8 + 12;
  localparam int BIT_W = $clog2(MAX_B + 1);

  logic [PRE_W-1:0] pcnt;
  logic [BIT_W-1:0] bcnt;
  logic [BIT_W-1:0] limit;
  logic             idle;
  logic             restart;
  logic             hit;

  always_comb begin
    limit   = BIT_W'(tmo_bits(word_len));
    idle    = (rx_level == '0) || !fifo_on;
    restart = stop_mid || rx_pop || idle;
    hit     = (bcnt >= limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt    <= '0;
      bcnt    <= '0;
      to_pend <= 1'b0;
    end else begin
      if (restart) begin
        pcnt <= '0;
        bcnt <= '0;
      end else if (tick && !hit) begin
        if (pcnt == PRE_W'(OVS - 1)) begin
          pcnt <= '0;
          bcnt <= bcnt + 1'b1;
        end else begin
          pcnt <= pcnt + 1'b1;
        end
      end
      if (rx_pop || idle) to_pend <= 1'b0;
      else if (hit)       to_pend <= 1'b1;
    end
  end

  assert_count_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= BIT_W'(MAX_B));

  assert_pop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |=> !to_pend);

  assert_empty_no_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |=> !to_pend);

  assert_legacy_no_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_on |=> !to_pend);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   src_line,
  input  logic                   src_rxd,
  input  logic                   src_tmo,
  input  logic                   src_tx,
  input  logic                   src_ms,
  output uart_irq_pkg::irq_id_e  id,
  output logic                   irq
);
  import uart_irq_pkg::*;

  logic [4:0] raw;
  logic [4:0] sel;

  always_comb begin
    raw = {src_line, src_rxd, src_tmo, src_tx, src_ms};
    sel = '0;
    for (int i = 4; i >= 0; i--) begin
      if (raw[i] && (sel == '0)) sel[i] = 1'b1;
    end
    unique case (1'b1)
      sel[4]:  id = ID_LINE;
      sel[3]:  id = ID_RXDATA;
      sel[2]:  id = ID_RXTMO;
      sel[1]:  id = ID_TXEMPTY;
      sel[0]:  id = ID_MODEM;
      default: id = ID_NONE;
    endcase
    irq = |raw;
  end

  assert_single_winner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  assert_irq_vs_id_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (id != ID_NONE));

  assert_line_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    src_line |-> id == ID_LINE);

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int LVL_W = 5,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick16,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_stop_mid,
  input  logic             rx_pop,
  input  logic             line_err,
  input  logic             thr_empty_evt,
  input  logic             msr_delta,
  input  logic [1:0]       word_len,
  input  logic             wr_ier,
  input  logic             wr_fcr,
  input  logic             wr_thr,
  input  logic             rd_isr,
  input  logic             rd_lsr,
  input  logic [7:0]       wdata,
  output logic             irq,
  output logic [7:0]       isr_rdata,
  output logic [7:0]       ier_rdata
);
  import uart_irq_pkg::*;

  logic [3:0] ier;
  logic       fifo_on;
  logic [1:0] trig_sel;
  logic       at_trig;
  logic       to_pend;
  logic       ls_pend;
  logic       tx_pend;
  logic       tx_ack;
  irq_id_e    id;

  uart_irq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_ier(wr_ier), .wr_fcr(wr_fcr), .wdata(wdata),
    .ier(ier), .fifo_on(fifo_on), .trig_sel(trig_sel)
  );

  uart_irq_trig #(.LVL_W(LVL_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .fifo_on(fifo_on),
    .trig_sel(trig_sel), .at_trig(at_trig)
  );

  uart_irq_tmo #(.LVL_W(LVL_W), .OVS(OVS)) u_tmo (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .fifo_on(fifo_on),
    .rx_level(rx_level), .stop_mid(rx_stop_mid), .rx_pop(rx_pop),
    .word_len(word_len), .to_pend(to_pend)
  );

  uart_irq_prio u_prio (
    .clk(clk), .rst_n(rst_n),
    .src_line(ls_pend & ier[2]),
    .src_rxd(at_trig & ier[0]),
    .src_tmo(to_pend & ier[0]),
    .src_tx(tx_pend & ier[1]),
    .src_ms(msr_delta & ier[3]),
    .id(id), .irq(irq)
  );

  assign tx_ack = rd_isr && (id == ID_TXEMPTY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ls_pend <= 1'b0;
      tx_pend <= 1'b0;
    end else begin
      if (line_err)    ls_pend <= 1'b1;
      else if (rd_lsr) ls_pend <= 1'b0;
      if (thr_empty_evt)          tx_pend <= 1'b1;
      else if (wr_thr || tx_ack)  tx_pend <= 1'b0;
    end
  end

  assign isr_rdata = {{2{fifo_on}}, 2'b00, id};
  assign ier_rdata = {4'b0000, ier};

  assert_error_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    line_err |=> ls_pend);

  assert_lsr_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !line_err) |=> !ls_pend);

  assert_thr_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_thr && !thr_empty_evt) |=> !tx_pend);

  assert_other_read_keeps_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_isr && tx_pend && id != ID_TXEMPTY && !wr_thr) |=> tx_pend);

endmodule

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic [4:0] rx_level = 5'd0;
  logic       rx_stop_mid = 1'b0, rx_pop = 1'b0, line_err = 1'b0;
  logic       thr_empty_evt = 1'b0, msr_delta = 1'b0;
  logic [1:0] word_len = 2'd0;
  logic       wr_ier = 1'b0, wr_fcr = 1'b0, wr_thr = 1'b0;
  logic       rd_isr = 1'b0, rd_lsr = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic       irq;
  logic [7:0] isr_rdata, ier_rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_level(rx_level),
    .rx_stop_mid(rx_stop_mid), .rx_pop(rx_pop), .line_err(line_err),
    .thr_empty_evt(thr_empty_evt), .msr_delta(msr_delta), .word_len(word_len),
    .wr_ier(wr_ier), .wr_fcr(wr_fcr), .wr_thr(wr_thr), .rd_isr(rd_isr),
    .rd_lsr(rd_lsr), .wdata(wdata), .irq(irq), .isr_rdata(isr_rdata),
    .ier_rdata(ier_rdata)
  );

  // {ier[3:0], line_err, thr_empty, msr_delta, level[4:0], isr[7:0], irq}
  localparam logic [20:0] VEC [12] = '{
    {4'hF, 1'b0, 1'b0, 1'b0, 5'd0, 8'hC1, 1'b0},
    {4'hF, 1'b1, 1'b1, 1'b1, 5'd5, 8'hC6, 1'b1},
    {4'hF, 1'b0, 1'b1, 1'b1, 5'd5, 8'hC4, 1'b1},
    {4'hF, 1'b0, 1'b1, 1'b1, 5'd3, 8'hC2, 1'b1},
    {4'hF, 1'b0, 1'b0, 1'b1, 5'd0, 8'hC0, 1'b1},
    {4'h0, 1'b1, 1'b1, 1'b1, 5'd5, 8'hC1, 1'b0},
    {4'hB, 1'b1, 1'b1, 1'b0, 5'd0, 8'hC2, 1'b1},
    {4'h4, 1'b1, 1'b0, 1'b0, 5'd0, 8'hC6, 1'b1},
    {4'h1, 1'b0, 1'b0, 1'b0, 5'd4, 8'hC4, 1'b1},
    {4'h1, 1'b0, 1'b0, 1'b0, 5'd3, 8'hC1, 1'b0},
    {4'h2, 1'b0, 1'b1, 1'b1, 5'd0, 8'hC2, 1'b1},
    {4'h8, 1'b0, 1'b1, 1'b1, 5'd0, 8'hC0, 1'b1}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic put_ier(input logic [7:0] d);
    wdata = d; wr_ier = 1'b1; step(1); wr_ier = 1'b0;
  endtask

  task automatic put_fcr(input logic [7:0] d);
    wdata = d; wr_fcr = 1'b1; step(1); wr_fcr = 1'b0;
  endtask

  task automatic clear_events();
    rd_lsr = 1'b1; wr_thr = 1'b1; step(1); rd_lsr = 1'b0; wr_thr = 1'b0;
  endtask

  function automatic int idle_ticks(input logic [1:0] wl);
    return (int'(wl) + 5) * 64 + 192;
  endfunction

  function automatic logic [4:0] level_for(input int code);
    case (code)
      0: return 5'd1;
      1: return 5'd4;
      2: return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 isr", isr_rdata, 8'h01);
    chk("R1 ier", ier_rdata, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R2 upper enable bits read zero
    put_ier(8'hFF);
    chk("R2 ier readback", ier_rdata, 8'h0F);

    // R6 legacy mode ignores trigger code
    put_fcr(8'hC0);
    put_ier(8'h01);
    rx_level = 5'd1; step(1);
    chk("R6 legacy rx byte", isr_rdata, 8'h04);
    rx_level = 5'd0; step(1);
    chk("R6 legacy empty", isr_rdata, 8'h01);

    // R3 R4 table: FIFO on, trigger 4
    put_fcr(8'h41);
    for (int i = 0; i < 12; i++) begin
      clear_events();
      msr_delta = VEC[i][14];
      rx_level  = VEC[i][13:9];
      put_ier({4'h0, VEC[i][20:17]});
      line_err = VEC[i][16]; thr_empty_evt = VEC[i][15];
      step(1);
      line_err = 1'b0; thr_empty_evt = 1'b0;
      chk("R3 table isr", isr_rdata, VEC[i][8:1]);
      chk("R4 table irq", {7'd0, irq}, {7'd0, VEC[i][0]});
    end
    msr_delta = 1'b0; rx_level = 5'd0;
    clear_events();

    // R5 trigger levels
    put_ier(8'h01);
    for (int c = 0; c < 4; c++) begin
      put_fcr({c[1:0], 5'd0, 1'b1});
      rx_level = level_for(c) - 5'd1; step(1);
      chk("R5 below trigger", isr_rdata, 8'hC1);
      rx_level = level_for(c); step(1);
      chk("R5 at trigger", isr_rdata, 8'hC4);
    end

    // R7 R8 timeout
    put_fcr(8'h41);
    rx_level = 5'd2;
    tick16 = 1'b1;
    for (int w = 0; w < 4; w += 3) begin
      word_len = w[1:0];
      rx_pop = 1'b1; step(1); rx_pop = 1'b0;
      step(idle_ticks(w[1:0]));
      chk("R7 just before limit", isr_rdata, 8'hC1);
      step(1);
      chk("R7 timeout id", isr_rdata, 8'hCC);
      chk("R7 timeout irq", {7'd0, irq}, 8'h01);
    end
    rx_pop = 1'b1; step(1); rx_pop = 1'b0;
    chk("R8 pop clears timeout", isr_rdata, 8'hC1);
    step(idle_ticks(2'd3) - 8);
    rx_stop_mid = 1'b1; step(1); rx_stop_mid = 1'b0;
    step(idle_ticks(2'd3));
    chk("R8 stop restart holds", isr_rdata, 8'hC1);
    step(1);
    chk("R8 stop restart fires", isr_rdata, 8'hCC);
    rx_level = 5'd0; step(1);
    chk("R8 empty clears", isr_rdata, 8'hC1);
    step(idle_ticks(2'd3) + 5);
    chk("R8 empty never times out", isr_rdata, 8'hC1);
    tick16 = 1'b0;

    // R9 transmit empty
    put_ier(8'h02);
    thr_empty_evt = 1'b1; step(1); thr_empty_evt = 1'b0;
    chk("R9 tx set", isr_rdata, 8'hC2);
    rd_isr = 1'b1; step(1); rd_isr = 1'b0;
    chk("R9 isr read clears", isr_rdata, 8'hC1);
    put_ier(8'h06);
    line_err = 1'b1; thr_empty_evt = 1'b1; step(1);
    line_err = 1'b0; thr_empty_evt = 1'b0;
    rd_isr = 1'b1; step(1); rd_isr = 1'b0;
    chk("R9 masked by line", isr_rdata, 8'hC6);
    rd_lsr = 1'b1; step(1); rd_lsr = 1'b0;
    chk("R9 tx survives other read", isr_rdata, 8'hC2);

    // R10 collision of new error with status read
    line_err = 1'b1; step(1); line_err = 1'b0;
    line_err = 1'b1; rd_lsr = 1'b1; step(1); line_err = 1'b0; rd_lsr = 1'b0;
    chk("R10 error wins", isr_rdata, 8'hC6);
    rd_lsr = 1'b1; step(1); rd_lsr = 1'b0;
    wr_thr = 1'b1; step(1); wr_thr = 1'b0;
    chk("R10 read clears", isr_rdata, 8'hC1);

    // R11 modem level
    put_ier(8'h08);
    msr_delta = 1'b1; step(1);
    chk("R11 modem id", isr_rdata, 8'hC0);
    chk("R11 modem irq", {7'd0, irq}, 8'h01);
    msr_delta = 1'b0; step(1);
    chk("R11 modem gone", isr_rdata, 8'hC1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule